// File: doc/BRIEF.md
# Filtered Cell Statistics Counter Bank

This block sits beside a cell transmit path and keeps two statistics counters: one for transmitted cells that belong to a single chosen connection on a single chosen PHY port, and one for idle cells sent on that same port. Each transmitted cell is presented for one clock with its PHY address and its 32-bit header. The block compares these against configuration registers and advances the matching counters.

Software reads the counters through a single-cycle register port. A read never changes a counter. A counter returns to zero only when software writes to a dedicated clear register. Each counter has a sticky flag that records a wrap from its maximum value to zero. A per-counter mask turns a set flag into an interrupt request.

Top module: `cell_stat_bank`

## Requirements
- R1: After reset both counters, both overflow flags and the mask read as zero, and `irq_o` is low.
- R2: The cell counter advances by one for each cycle with `cell_vld_i` high, `cell_phy_i` equal to the PHY match register, and header VPI (bits 27:20) and VCI (bits 19:4) equal to the connection match register. GFC (31:28), PTI (3:1) and CLP (0) take no part in the match.
- R3: The idle counter advances by one for each valid cell on the matching PHY whose header bits 27:0 are VPI=0, VCI=0, PTI=0, CLP=1. This holds whatever the connection match register contains.
- R4: A cell on any other PHY address, or any cycle with `cell_vld_i` low, changes neither counter.
- R5: Reading any register leaves the counters and flags unchanged.
- R6: A write to offset 3 clears the counters selected by the write data. Bit 0 clears the cell counter and its flag. Bit 1 clears the idle counter and its flag. A counter whose bit is zero keeps its value.
- R7: A counter that steps from all ones to zero sets its overflow flag. The flag stays set through further counting until that counter is cleared. Offset 2 reads the flags, cell flag in bit 0 and idle flag in bit 1.
- R8: When a clear and a count for the same counter fall in the same cycle, the counter ends at zero with its flag clear.
- R9: `irq_o` is high exactly when some overflow flag is set and its mask bit (offset 4, bit 0 cell, bit 1 idle) is set.
- R10: Register map: 0 cell count, 1 idle count, 2 flags, 3 clear (reads zero), 4 mask, 5 PHY match, 6 connection match (VPI in bits 23:16, VCI in bits 15:0). Read data is zero-extended. Writes to offsets 0, 1 and 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cell_vld_i | input | 1 | One transmitted cell this cycle |
| cell_phy_i | input | PHY_W | PHY address of the cell |
| cell_hdr_i | input | 32 | Cell header (GFC, VPI, VCI, PTI, CLP) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i`, same cycle |
| irq_o | output | 1 | Masked overflow interrupt |

## Verification
The match logic is swept over every PHY address of a 2-bit configuration. For each address the bench sends all sixteen PTI/CLP combinations on the matched connection, which shows that those header fields are ignored. It also sends near misses that differ from the match only in VPI or only in VCI, which shows that each field is compared on its own. It separates the idle pattern from the unassigned pattern (CLP=0) and from idle with a nonzero PTI, and it sends matching headers with the valid strobe low. With an 8-bit counter, runs of several hundred cells make both counters wrap, which tests flag stickiness and masking. A clear written in the same cycle as a matching cell tests the clear priority. Retargeting the connection match to 0/0 makes an idle cell count in both counters at once.

// File: rtl/cstat_pkg.sv
package cstat_pkg;
  localparam int NUM_CNT  = 2;
  localparam int CNT_CELL = 0;
  localparam int CNT_IDLE = 1;
  localparam int REG_AW   = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_CELL = 3'd0,
    RA_IDLE = 3'd1,
    RA_OVF  = 3'd2,
    RA_CLR  = 3'd3,
    RA_MASK = 3'd4,
    RA_PHY  = 3'd5,
    RA_VC   = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic [3:0]  gfc;
    logic [7:0]  vpi;
    logic [15:0] vci;
    logic [2:0]  pti;
    logic        clp;
  } cell_hdr_t;

  localparam int HDR_W = $bits(cell_hdr_t);
endpackage

// File: rtl/cstat_classify.sv
module cstat_classify
  import cstat_pkg::*;
#(
  parameter int PHY_W = 5
) (
  input  logic                 vld_i,
  input  logic [PHY_W-1:0]     phy_i,
  input  cell_hdr_t            hdr_i,
  input  logic [PHY_W-1:0]     match_phy_i,
  input  logic [7:0]           match_vpi_i,
  input  logic [15:0]          match_vci_i,
  output logic [NUM_CNT-1:0]   hit_o
);
  logic port_ok, vc_ok, idle_ok;

  always_comb begin
    port_ok = vld_i && (phy_i == match_phy_i);
    vc_ok   = (hdr_i.vpi == match_vpi_i) && (hdr_i.vci == match_vci_i);
    // idle: VPI/VCI/PTI all zero with CLP set; GFC not examined
    idle_ok = (hdr_i.vpi == '0) && (hdr_i.vci == '0) &&
              (hdr_i.pti == '0) && hdr_i.clp;
    hit_o           = '0;
    hit_o[CNT_CELL] = port_ok && vc_ok;
    hit_o[CNT_IDLE] = port_ok && idle_ok;
  end
endmodule

// File: rtl/cstat_counter.sv
module cstat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_MAX) ovf_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/cstat_regs.sv
module cstat_regs
  import cstat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int PHY_W  = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [REG_AW-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]   cnt_cell_i,
  input  logic [CNT_W-1:0]   cnt_idle_i,
  input  logic [NUM_CNT-1:0] ovf_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_CNT-1:0] clr_o,
  output logic [NUM_CNT-1:0] mask_o,
  output logic [PHY_W-1:0]   match_phy_o,
  output logic [7:0]         match_vpi_o,
  output logic [15:0]        match_vci_o
);
  reg_addr_e addr;
  assign addr = reg_addr_e'(addr_i);

  logic [NUM_CNT-1:0] mask_q;
  logic [PHY_W-1:0]   phy_q;
  logic [7:0]         vpi_q;
  logic [15:0]        vci_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      phy_q  <= '0;
      vpi_q  <= '0;
      vci_q  <= '0;
    end else if (we_i) begin
      unique case (addr)
        RA_MASK: mask_q <= wdata_i[NUM_CNT-1:0];
        RA_PHY:  phy_q  <= wdata_i[PHY_W-1:0];
        RA_VC: begin
          vpi_q <= wdata_i[23:16];
          vci_q <= wdata_i[15:0];
        end
        default: ;
      endcase
    end
  end

  // clear is a pulse, not a stored register
  assign clr_o = (we_i && addr == RA_CLR) ? wdata_i[NUM_CNT-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    unique case (addr)
      RA_CELL: rdata_o[CNT_W-1:0]   = cnt_cell_i;
      RA_IDLE: rdata_o[CNT_W-1:0]   = cnt_idle_i;
      RA_OVF:  rdata_o[NUM_CNT-1:0] = ovf_i;
      RA_MASK: rdata_o[NUM_CNT-1:0] = mask_q;
      RA_PHY:  rdata_o[PHY_W-1:0]   = phy_q;
      RA_VC: begin
        rdata_o[23:16] = vpi_q;
        rdata_o[15:0]  = vci_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign mask_o      = mask_q;
  assign match_phy_o = phy_q;
  assign match_vpi_o = vpi_q;
  assign match_vci_o = vci_q;
endmodule

// File: rtl/cell_stat_bank.sv
module cell_stat_bank
  import cstat_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PHY_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cell_vld_i,
  input  logic [PHY_W-1:0]  cell_phy_i,
  input  logic [31:0]       cell_hdr_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [NUM_CNT-1:0] hit;
  logic [NUM_CNT-1:0] clr_vec;
  logic [NUM_CNT-1:0] mask;
  logic [NUM_CNT-1:0] ovf;
  logic [CNT_W-1:0]   cnt [NUM_CNT];
  logic [CNT_W-1:0]   cnt_cell, cnt_idle;
  logic [PHY_W-1:0]   match_phy;
  logic [7:0]         match_vpi;
  logic [15:0]        match_vci;

  cstat_classify #(.PHY_W(PHY_W)) u_classify (
    .vld_i       (cell_vld_i),
    .phy_i       (cell_phy_i),
    .hdr_i       (cell_hdr_t'(cell_hdr_i)),
    .match_phy_i (match_phy),
    .match_vpi_i (match_vpi),
    .match_vci_i (match_vci),
    .hit_o       (hit)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    cstat_counter #(.CNT_W(CNT_W)) u_counter (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (hit[g]),
      .clr_i  (clr_vec[g]),
      .cnt_o  (cnt[g]),
      .ovf_o  (ovf[g])
    );
  end

  assign cnt_cell = cnt[CNT_CELL];
  assign cnt_idle = cnt[CNT_IDLE];

  cstat_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PHY_W(PHY_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .cnt_cell_i  (cnt_cell),
    .cnt_idle_i  (cnt_idle),
    .ovf_i       (ovf),
    .rdata_o     (reg_rdata_o),
    .clr_o       (clr_vec),
    .mask_o      (mask),
    .match_phy_o (match_phy),
    .match_vpi_o (match_vpi),
    .match_vci_o (match_vci)
  );

  assign irq_o = |(ovf & mask);
endmodule

// File: rtl/cell_stat_bank_chk.sv
module cell_stat_bank_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cell_vld_i,
  input logic [1:0]       hit_i,
  input logic [1:0]       clr_i,
  input logic [CNT_W-1:0] cnt_cell_i,
  input logic [CNT_W-1:0] cnt_idle_i,
  input logic [1:0]       ovf_i,
  input logic             irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_NO_VLD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cell_vld_i && clr_i == 2'b00) |=> ($stable(cnt_cell_i) && $stable(cnt_idle_i))); // R4

  AST_IDLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i[1] && !clr_i[1]) |=> (cnt_idle_i == CNT_W'($past(cnt_idle_i) + 1'b1))); // R3

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i[0] && !clr_i[0] && cnt_cell_i == CNT_MAX) |=> (ovf_i[0] && cnt_cell_i == '0)); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i[0] && !clr_i[0]) |=> ovf_i[0]); // R7

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i[0] |=> (cnt_cell_i == '0 && !ovf_i[0])); // R8

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ovf_i != 2'b00)); // R9
endmodule

bind cell_stat_bank cell_stat_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cell_vld_i (cell_vld_i),
  .hit_i      (hit),
  .clr_i      (clr_vec),
  .cnt_cell_i (cnt_cell),
  .cnt_idle_i (cnt_idle),
  .ovf_i      (ovf),
  .irq_o      (irq_o)
);

// File: tb/cell_stat_bank_test.sv
`timescale 1ns/1ps
module cell_stat_bank_test;
  localparam int CNT_W = 8, PHY_W = 2, DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cell_vld = 1'b0;
  logic [PHY_W-1:0]  cell_phy = '0;
  logic [31:0]       cell_hdr = '0;
  logic              reg_we = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              irq;

  int n_chk = 0, n_fail = 0;
  logic [PHY_W-1:0] m_phy = '0;
  logic [7:0]       m_vpi = '0;
  logic [15:0]      m_vci = '0;
  logic [CNT_W-1:0] exp_cell = '0, exp_idle = '0;
  logic [1:0]       exp_ovf = '0;

  always #2.5 clk = ~clk;

  cell_stat_bank #(.CNT_W(CNT_W), .PHY_W(PHY_W), .DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cell_vld_i(cell_vld), .cell_phy_i(cell_phy),
    .cell_hdr_i(cell_hdr), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  function automatic logic [31:0] mk(input logic [7:0] vpi, input logic [15:0] vci,
                                     input logic [2:0] pti, input logic clp);
    return {4'h0, vpi, vci, pti, clp};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk); reg_addr = a; #1;
    check(req, reg_rdata, exp);
  endtask

  // bench model written from R2/R3/R7
  task automatic model_cell(input logic [PHY_W-1:0] p, input logic [31:0] h);
    if (p == m_phy) begin
      if (h[27:20] == m_vpi && h[19:4] == m_vci) begin
        if (exp_cell == '1) exp_ovf[0] = 1'b1;
        exp_cell = exp_cell + 1'b1;
      end
      if (h[27:0] == 28'h1) begin
        if (exp_idle == '1) exp_ovf[1] = 1'b1;
        exp_idle = exp_idle + 1'b1;
      end
    end
  endtask

  task automatic send(input logic [PHY_W-1:0] p, input logic [31:0] h, input logic v);
    @(negedge clk); cell_vld = v; cell_phy = p; cell_hdr = h;
    @(negedge clk); cell_vld = 1'b0;
    if (v) model_cell(p, h);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] first;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd_chk("R1 cell", 3'd0, 0);
    rd_chk("R1 idle", 3'd1, 0);
    rd_chk("R1 ovf", 3'd2, 0);
    rd_chk("R1 mask", 3'd4, 0);
    check("R1 irq", {31'd0, irq}, 0);

    // R10 configuration readback
    wr(3'd5, 32'h2); m_phy = 2'd2;
    wr(3'd6, 32'h0005_0123); m_vpi = 8'h05; m_vci = 16'h0123;
    rd_chk("R10 phy", 3'd5, 32'h2);
    rd_chk("R10 vc", 3'd6, 32'h0005_0123);
    rd_chk("R10 clear reads zero", 3'd3, 0);

    // R2 R3 R4 sweep over every PHY address
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 16; k++)
        send(PHY_W'(p), mk(8'h05, 16'h0123, 3'(k >> 1), k[0]), 1'b1);
      send(PHY_W'(p), mk(8'h06, 16'h0123, 3'd0, 1'b0), 1'b1);
      send(PHY_W'(p), mk(8'h05, 16'h0124, 3'd0, 1'b0), 1'b1);
      send(PHY_W'(p), mk(8'h00, 16'h0000, 3'd0, 1'b1), 1'b1);
      send(PHY_W'(p), mk(8'h00, 16'h0000, 3'd0, 1'b0), 1'b1);
      send(PHY_W'(p), mk(8'h00, 16'h0000, 3'd1, 1'b1), 1'b1);
      send(PHY_W'(p), mk(8'h05, 16'h0123, 3'd0, 1'b0), 1'b0);
      send(PHY_W'(p), mk(8'h00, 16'h0000, 3'd0, 1'b1), 1'b0);
    end
    rd_chk("R2 cell after sweep", 3'd0, 16);
    rd_chk("R3 idle after sweep", 3'd1, 1);
    rd_chk("R4 model cell", 3'd0, 32'(exp_cell));

    // R5 reads leave values alone
    @(negedge clk); reg_addr = 3'd0; #1; first = reg_rdata;
    repeat (4) @(negedge clk);
    rd_chk("R5 repeat read", 3'd0, first);
    rd_chk("R5 idle kept", 3'd1, 1);

    // R10 writes to read-only offsets ignored
    wr(3'd0, 32'hAA); wr(3'd1, 32'h55); wr(3'd2, 32'h3);
    rd_chk("R10 cell ro", 3'd0, 16);
    rd_chk("R10 idle ro", 3'd1, 1);
    rd_chk("R10 ovf ro", 3'd2, 0);

    // R6 selective clear
    wr(3'd3, 32'h2); exp_idle = '0; exp_ovf[1] = 1'b0;
    rd_chk("R6 idle cleared", 3'd1, 0);
    rd_chk("R6 cell kept", 3'd0, 16);

    // R7 wrap of cell counter
    for (int i = 0; i < 250; i++) send(2'd2, mk(8'h05, 16'h0123, 3'd0, 1'b0), 1'b1);
    rd_chk("R7 cell wrapped", 3'd0, (16 + 250) % 256);
    rd_chk("R7 flag set", 3'd2, 32'h1);
    check("R9 masked off", {31'd0, irq}, 0);
    wr(3'd4, 32'h2);
    check("R9 other mask", {31'd0, irq}, 0);
    wr(3'd4, 32'h1);
    check("R9 mask on", {31'd0, irq}, 1);
    for (int i = 0; i < 5; i++) send(2'd2, mk(8'h05, 16'h0123, 3'd0, 1'b0), 1'b1);
    rd_chk("R7 sticky", 3'd2, 32'h1);
    rd_chk("R7 count on", 3'd0, 15);

    // R8 clear and count in the same cycle
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h1;
    cell_vld = 1'b1; cell_phy = 2'd2; cell_hdr = mk(8'h05, 16'h0123, 3'd0, 1'b0);
    @(negedge clk); reg_we = 1'b0; cell_vld = 1'b0;
    exp_cell = '0; exp_ovf[0] = 1'b0;
    rd_chk("R8 cell zero", 3'd0, 0);
    rd_chk("R8 flag clear", 3'd2, 0);
    check("R8 irq low", {31'd0, irq}, 0);

    // R3 R7 idle wrap with connection match on 0/0
    wr(3'd6, 32'h0); m_vpi = '0; m_vci = '0;
    for (int i = 0; i < 257; i++) send(2'd2, mk(8'h00, 16'h0000, 3'd0, 1'b1), 1'b1);
    rd_chk("R3 idle wrap", 3'd1, 32'(exp_idle));
    rd_chk("R2 cell on 0/0", 3'd0, 1);
    rd_chk("R7 both flags", 3'd2, 32'(exp_ovf));
    wr(3'd4, 32'h2);
    check("R9 idle mask", {31'd0, irq}, 1);
    wr(3'd3, 32'h3);
    rd_chk("R6 both cleared", 3'd2, 0);
    rd_chk("R6 idle zero", 3'd1, 0);
    check("R9 irq after clear", {31'd0, irq}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule